// File: doc/BRIEF.md
# Data-bus line pattern tester

This block is a hardware self-test engine for a wide memory data path. It looks for data lines that are shorted to a neighbour, stuck, or open. On a start pulse it walks through a fixed list of test words. It writes each word to one memory location and reads the same location straight back. It then compares the returned word with the word it wrote, and only after that moves on to the next entry.

The list is built from the data width. For a width of W bits there are log2(W) base words. The base word number k takes bit i from bit k of the index i, so runs of 1, 2, 4 … W/2 equal bits alternate. After the base words come their bitwise complements in reverse order. This gives 2·log2(W) words in total, and every pair of lines is driven to opposite values in at least one word, however the lines are routed on the board.

The engine stops at the first mismatch. It reports fail and holds the failing word. If every word returns intact it reports pass. The memory side is a simple synchronous port: the engine issues a one-cycle read and then waits for a read-valid strobe, so the read latency of the memory does not matter.

Top module: `dbus_line_tester`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, pass, fail, mem_we and mem_re are all 0 and fail_pattern is all zeros.
- R2: For a 64-bit word the patterns are applied in exactly this order: AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000, FFFFFFFF00000000, 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF00FF00FF, 0F0F0F0F0F0F0F0F, 3333333333333333, 5555555555555555 (hex). Each pattern goes out as one write, and that write is followed by one read before the next write.
- R3: Every write and every read uses the address given by the TEST_ADDR parameter.
- R4: mem_we and mem_re are never high in the same cycle.
- R5: A returned word is compared only in a cycle where mem_rvalid is high. A memory that is two cycles slower per read makes a full run last exactly two cycles longer per pattern.
- R6: When all patterns match, done pulses high for exactly one cycle with pass=1 and fail=0.
- R7: At the first mismatch the run ends with fail=1, pass=0, and fail_pattern equal to the pattern that was written. No further write or read is issued.
- R8: A start pulse while busy is high has no effect: the run keeps its pattern order, issues 12 writes and gives a single done pulse.
- R9: pass, fail and fail_pattern keep their values after done until the next accepted start, which clears all three.
- R10: busy is high from the cycle after an accepted start until the cycle in which done is high, and it is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse, accepted only while idle |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Last run matched all patterns |
| fail | output | 1 | Last run found a mismatch |
| fail_pattern | output | DATA_W (64) | Pattern that mismatched, otherwise zero |
| mem_addr | output | ADDR_W (16) | Memory address, TEST_ADDR during an access |
| mem_wdata | output | DATA_W (64) | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read request, one cycle |
| mem_rdata | input | DATA_W (64) | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data valid strobe |

## Verification
A wrong pattern index shows up as an out-of-order word on mem_wdata on the very next write strobe. With a stuck line, the failure is reported with the exact failing pattern no more than one cycle after the corrupted read returns. A sequencer that does not wait for mem_rvalid samples junk read data and reports fail on the first pattern. The bench catches this within a handful of cycles, and the same fault also changes the run length that the bench compares across two latencies. A result register that is not held or not cleared becomes visible idle cycles after done, or in the first busy cycle of the next run.

// File: rtl/dbt_pkg.sv
// Shared definitions for the data-bus line pattern tester.
// Assumes the data width is a power of two of at least 2.
package dbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_t;

    // Number of test words for a given data width: base patterns plus complements.
    function automatic int unsigned pattern_total(input int unsigned width);
        return 2 * $clog2(width);
    endfunction

endpackage

// File: rtl/dbt_pattern_rom.sv
// Pattern table for the line tester, generated from the width.
// Row k (k < log2(W)) sets bit i to bit k of the index i. Row
// NUM_PAT-1-k holds the complement of row k, so the complements follow
// the base rows in reverse order. Rows beyond NUM_PAT read as zero.
// Assumes DATA_W is a power of two.
module dbt_pattern_rom #(
    parameter int DATA_W = 64,
    parameter int NUM_PAT = 12,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] pattern
);
    localparam int NUM_BASE = NUM_PAT / 2;
    localparam int DEPTH    = 2 ** IDX_W;

    logic [DATA_W-1:0] rows [DEPTH];

    // Base rows and their complements.
    for (genvar k = 0; k < NUM_BASE; k++) begin : g_base
        logic [DATA_W-1:0] base_w;
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign base_w[b] = (((b >> k) % 2) == 1);
        end
        assign rows[k]             = base_w;
        assign rows[NUM_PAT-1-k]   = ~base_w;
    end

    // Unused rows of the power-of-two table.
    for (genvar p = NUM_PAT; p < DEPTH; p++) begin : g_pad
        assign rows[p] = '0;
    end

    // Table lookup.
    assign pattern = rows[idx];

endmodule

// File: rtl/dbt_seq.sv
// Sequencer for the line tester. For each pattern index it issues one
// write cycle, one read cycle, then waits for the read-valid strobe. A
// mismatch or the last index ends the run. Start is honoured only while
// idle. Assumes the memory returns read data at least one cycle after
// the read request.
module dbt_seq
    import dbt_pkg::*;
#(
    parameter int NUM_PAT = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_valid,
    input  logic             mismatch,
    output logic             busy,
    output logic             do_write,
    output logic             do_read,
    output logic             accept,
    output logic             end_pass,
    output logic             end_fail,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAT - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             at_last;

    assign at_last  = (idx_q == LAST_IDX);
    assign accept   = (state_q == ST_IDLE) && start;
    assign end_fail = (state_q == ST_WAIT) && rd_valid && mismatch;
    assign end_pass = (state_q == ST_WAIT) && rd_valid && !mismatch && at_last;

    // Next-state and index logic.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_WRITE;
                    idx_d   = '0;
                end
            end
            ST_WRITE: state_d = ST_READ;
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    if (mismatch || at_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_WRITE;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign do_write = (state_q == ST_WRITE);
    assign do_read  = (state_q == ST_READ);
    assign idx      = idx_q;

endmodule

// File: rtl/dbt_result.sv
// Result holder for the line tester. It registers the done pulse and the
// pass/fail verdict, and captures the failing pattern. All of them are
// cleared when a new run is accepted. Assumes end_pass and end_fail are
// never high together.
module dbt_result #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              end_pass,
    input  logic              end_fail,
    input  logic [DATA_W-1:0] exp_pattern,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [DATA_W-1:0] fail_pattern
);
    // Verdict, pulse and failing-word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            pass         <= 1'b0;
            fail         <= 1'b0;
            fail_pattern <= '0;
        end else begin
            done <= end_pass || end_fail;
            if (clear) begin
                pass         <= 1'b0;
                fail         <= 1'b0;
                fail_pattern <= '0;
            end else if (end_fail) begin
                fail         <= 1'b1;
                fail_pattern <= exp_pattern;
            end else if (end_pass) begin
                pass <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbus_line_tester.sv
// Top of the data-bus line pattern tester. It writes each generated
// pattern to TEST_ADDR, reads it back, and compares the result when
// mem_rvalid arrives. It stops at the first mismatch. Assumes a
// synchronous memory that answers every read with exactly one
// mem_rvalid strobe.
module dbus_line_tester
    import dbt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TEST_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [DATA_W-1:0] fail_pattern,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    localparam int NUM_PAT = pattern_total(DATA_W);
    localparam int IDX_W   = $clog2(NUM_PAT);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] cur_pattern;
    logic              mismatch, accept, end_pass, end_fail;

    dbt_pattern_rom #(
        .DATA_W (DATA_W),
        .NUM_PAT(NUM_PAT),
        .IDX_W  (IDX_W)
    ) u_rom (
        .idx    (idx),
        .pattern(cur_pattern)
    );

    dbt_seq #(
        .NUM_PAT(NUM_PAT),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_valid(mem_rvalid),
        .mismatch(mismatch),
        .busy    (busy),
        .do_write(mem_we),
        .do_read (mem_re),
        .accept  (accept),
        .end_pass(end_pass),
        .end_fail(end_fail),
        .idx     (idx)
    );

    dbt_result #(
        .DATA_W(DATA_W)
    ) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .end_pass    (end_pass),
        .end_fail    (end_fail),
        .exp_pattern (cur_pattern),
        .done        (done),
        .pass        (pass),
        .fail        (fail),
        .fail_pattern(fail_pattern)
    );

    // Compare the returned word with the word written.
    assign mismatch  = (mem_rdata != cur_pattern);
    assign mem_addr  = (mem_we || mem_re) ? TEST_ADDR : '0;
    assign mem_wdata = mem_we ? cur_pattern : '0;

endmodule

// File: rtl/dbt_checker.sv
// Port-level properties of the line tester, bound to the top module.
module dbt_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TEST_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [DATA_W-1:0] fail_pattern,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              mem_rvalid
);
    // R4
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R2
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_re);

    // R3
    test_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr == TEST_ADDR));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    done_after_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rvalid));

    // R7
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R9
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pass) && $stable(fail) && $stable(fail_pattern)));

endmodule

bind dbus_line_tester dbt_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .TEST_ADDR(TEST_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .fail_pattern(fail_pattern),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_rvalid  (mem_rvalid)
);

// File: tb/tb_dbus_line_tester.sv
`timescale 1ns/1ps
// Directed bench for the line tester, with an ideal synchronous memory
// whose read latency and line faults are set per scenario.
module tb_dbus_line_tester;
    localparam int DW = 64;
    localparam int AW = 8;
    localparam logic [AW-1:0] TA = 8'd5;
    localparam logic [DW-1:0] JUNK = 64'h0123_4567_89AB_CDEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, pass, fail, mem_we, mem_re;
    logic [DW-1:0] fail_pattern, mem_wdata;
    logic [DW-1:0] mem_rdata = JUNK;
    logic          mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    dbus_line_tester #(.DATA_W(DW), .ADDR_W(AW), .TEST_ADDR(TA)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_pattern(fail_pattern),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // Memory model with fault injection.
    logic [DW-1:0] mem [256];
    int            lat = 1;
    logic [DW-1:0] stuck1 = '0;
    logic [DW-1:0] stuck0 = '0;
    bit            short_en = 1'b0;
    int            pend_cnt = 0;
    logic [DW-1:0] pend_data;

    function automatic logic [DW-1:0] faulty(input logic [DW-1:0] w);
        logic [DW-1:0] r;
        r = w;
        if (short_en) begin
            r[16] = w[16] & w[48];
            r[48] = w[16] & w[48];
        end
        return (r | stuck1) & ~stuck0;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        mem_rdata  <= JUNK;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (pend_cnt > 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pend_data;
            end
        end
        if (mem_re) begin
            if (lat <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= faulty(mem[mem_addr]);
            end else begin
                pend_cnt  <= lat - 1;
                pend_data <= faulty(mem[mem_addr]);
            end
        end
    end

    // Port monitor, sampled away from the active edge.
    logic [DW-1:0] wlog [32];
    int wcnt, rcnt, dcnt, addr_err, ord_err;
    bit wr_pend;

    always @(negedge clk) begin
        if (mem_we) begin
            if (wcnt < 32) wlog[wcnt] = mem_wdata;
            if (mem_addr != TA) addr_err++;
            if (wr_pend) ord_err++;
            wr_pend = 1'b1;
            wcnt++;
        end
        if (mem_re) begin
            if (mem_addr != TA) addr_err++;
            if (!wr_pend) ord_err++;
            wr_pend = 1'b0;
            rcnt++;
        end
        if (mem_we && mem_re) ord_err++;
        if (done) dcnt++;
    end

    // Expected pattern k, computed from the requirement text.
    function automatic logic [DW-1:0] exp_pat(input int k);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) begin
            if (k < 6) w[i] = ((i >> k) % 2) == 1;
            else       w[i] = ((i >> (11 - k)) % 2) == 0;
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        wcnt = 0; rcnt = 0; dcnt = 0; addr_err = 0; ord_err = 0; wr_pend = 1'b0;
    endtask

    // Pulse start, optionally pulse it again mid-run, wait for done.
    task automatic run(input int extra_start_at, output int cycles, output bit busy_ok);
        int c;
        busy_ok = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        c = 1;
        while (!done && c < 2000) begin
            if (!busy) busy_ok = 1'b0;
            if (c == extra_start_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            c++;
        end
        if (c >= 2000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=no done expected=done");
        end
        if (busy) busy_ok = 1'b0;
        cycles = c;
    endtask

    task automatic t_reset();
        check("R1 busy", {63'd0, busy}, '0);
        check("R1 done", {63'd0, done}, '0);
        check("R1 pass/fail", {62'd0, pass, fail}, '0);
        check("R1 we/re", {62'd0, mem_we, mem_re}, '0);
        check("R1 fail_pattern", fail_pattern, '0);
    endtask

    task automatic t_clean(output int cycles);
        bit bok;
        lat = 1; stuck1 = '0; stuck0 = '0; short_en = 0;
        clear_mon();
        run(0, cycles, bok);
        @(negedge clk);
        check("R6 pass", {62'd0, pass, fail}, 64'd2);
        check("R6 done single pulse", 64'(dcnt), 64'd1);
        check("R10 busy window", {63'd0, bok}, 64'd1);
        check("R2 write count", 64'(wcnt), 64'd12);
        check("R2 read count", 64'(rcnt), 64'd12);
        check("R2 order", 64'(ord_err), 64'd0);
        check("R4 exclusivity", 64'(ord_err), 64'd0);
        check("R3 address", 64'(addr_err), 64'd0);
        for (int k = 0; k < 12; k++) check($sformatf("R2 pattern %0d", k), wlog[k], exp_pat(k));
    endtask

    task automatic t_latency(input int base_cycles);
        int cyc;
        bit bok;
        lat = 3;
        clear_mon();
        run(0, cyc, bok);
        @(negedge clk);
        check("R5 slow pass", {62'd0, pass, fail}, 64'd2);
        check("R5 run length delta", 64'(cyc - base_cycles), 64'd24);
        lat = 1;
    endtask

    task automatic t_fault(input string tag, input int fail_idx);
        int cyc;
        bit bok;
        clear_mon();
        run(0, cyc, bok);
        repeat (3) @(negedge clk);
        check({"R7 verdict ", tag}, {62'd0, pass, fail}, 64'd1);
        check({"R7 fail_pattern ", tag}, fail_pattern, exp_pat(fail_idx));
        check({"R7 stop writes ", tag}, 64'(wcnt), 64'(fail_idx + 1));
        check({"R7 stop reads ", tag}, 64'(rcnt), 64'(fail_idx + 1));
        stuck1 = '0; stuck0 = '0; short_en = 0;
    endtask

    task automatic t_hold_and_clear();
        int cyc;
        bit bok;
        stuck1 = 64'h8000_0000_0000_0000;
        t_fault("hold setup", 6);
        repeat (20) @(negedge clk);
        check("R9 fail held", {62'd0, pass, fail}, 64'd1);
        check("R9 pattern held", fail_pattern, exp_pat(6));
        clear_mon();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R9 cleared on start", {62'd0, pass, fail}, 64'd0);
        check("R9 pattern cleared", fail_pattern, 64'd0);
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        @(negedge clk);
        check("R9 new verdict", {62'd0, pass, fail}, 64'd2);
        bok = 1'b1;
    endtask

    task automatic t_start_busy();
        int cyc;
        bit bok;
        clear_mon();
        run(10, cyc, bok);
        @(negedge clk);
        check("R8 writes", 64'(wcnt), 64'd12);
        check("R8 done count", 64'(dcnt), 64'd1);
        check("R8 pass", {62'd0, pass, fail}, 64'd2);
        for (int k = 0; k < 12; k++) check($sformatf("R8 order %0d", k), wlog[k], exp_pat(k));
        repeat (5) @(negedge clk);
        check("R8 idle after", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        #700us;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(base);
        t_latency(base);
        stuck1 = 64'h8000_0000_0000_0000;
        t_fault("stuck-high top line", 6);
        stuck0 = 64'h4;
        t_fault("stuck-low line 2", 1);
        short_en = 1'b1;
        t_fault("short 16/48", 5);
        t_hold_and_clear();
        t_start_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule